// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Static Memory Core

This block is a synthesizable word memory, 16 bits wide, split into two byte lanes. Each lane keeps its byte together with four check bits that are never seen at the port. The port behaves like a plain byte-controlled static RAM. It has an active-low chip select, output enable, write enable, and one active-low enable for each byte. The tristate data bus is split into a data input, a data output and a drive-enable bit for each lane, so a pad ring or a bus multiplexer can sit outside the block.

Commands are sampled on the rising clock edge. A small controller classifies each sampled command into one of four states: ST_DESEL (chip not selected), ST_NOOUT (selected but nothing is driven), ST_READ and ST_WRITE. The transitions are taken from the inputs of that cycle with this priority: chip select high goes to ST_DESEL; both byte enables high goes to ST_NOOUT; write enable low goes to ST_WRITE; output enable high goes to ST_NOOUT; everything else goes to ST_READ. The state register holds the state of the last sampled command, and the outputs are decoded from it. A write encodes only the lanes that are enabled. A read corrects a single flipped bit in each lane on its own and reports that correction on a flag for that lane.

The depth is set by the address-width parameter, so the full 19-bit address can be used in silicon and a small array in simulation. A test port can flip chosen stored bits so that the correction logic can be exercised.

Top module: `bl_ecc_sram`

## Requirements
- R1: While rst_n is low, and until the first command after it, dout_oe, dout and corr_flag are all zero and the controller rests in ST_DESEL.
- R2: An edge that samples ce_n high writes nothing, and in the next cycle dout_oe is 2'b00, whatever the other controls are.
- R3: With ce_n low, an edge that samples either we_n high with oe_n high, or ub_n and lb_n both high, writes nothing and gives dout_oe of 2'b00 in the next cycle.
- R4: An edge that samples ce_n low, we_n high and oe_n low is a read. In the next cycle dout_oe[0] equals the inverse of the sampled lb_n and dout_oe[1] the inverse of the sampled ub_n. A driven lane shows the stored byte at the sampled address (lower lane on dout[7:0], upper lane on dout[15:8]). An undriven lane shows zero.
- R5: An edge that samples ce_n low and we_n low stores din[7:0] when lb_n is low and din[15:8] when ub_n is low. The level of oe_n has no effect, and a disabled lane keeps its old contents.
- R6: Each lane is stored as a 12-bit codeword in which codeword bit k holds Hamming position k+1. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Each check bit gives even parity over the positions whose index contains its own weight.
- R7: On a read, a codeword with exactly one flipped bit, whether a data bit or a check bit, returns the original byte. In the same cycle as the data, corr_flag for that lane is 1.
- R8: The lanes are corrected independently. An error in one lane changes neither the data nor the flag of the other lane, and corr_flag is 1 only on a lane that is driven.
- R9: An edge with inj_en high XORs inj_mask into the stored codeword at inj_addr for each lane whose inj_lane bit is 1 (bit 0 is the lower lane). If the same edge writes the same lane at the same address, the write wins and the mask is dropped.
- R10: Reset does not change the stored contents.
- R11: A write to one lane re-encodes only that lane. It clears a stored error in that lane and leaves an error in the other lane in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the port logic |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data; [15:8] is the upper lane |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| dout | output | 16 | Read data; an undriven lane reads zero |
| dout_oe | output | 2 | Drive enable for each lane; bit 0 is the lower lane |
| corr_flag | output | 2 | Set when a lane's read data needed correction |
| inj_en | input | 1 | Test-only: apply the bit-flip mask at this edge |
| inj_addr | input | ADDR_W | Test-only: address of the word to corrupt |
| inj_lane | input | 2 | Test-only: lanes to corrupt; bit 0 is the lower lane |
| inj_mask | input | 12 | Test-only: codeword bits to flip |

## Verification
The assertions assume that every control input is a known level at each sampled edge after reset. They also assume that at most one bit of any lane codeword is flipped between two writes to it, because only a single-bit error is promised to come back corrected. The stimulus uses only single-bit injection masks. It rewrites a lane before it corrupts that lane again, and it reads only addresses that have been written. Reset is asserted only while the clock is low, so the checker never sees a half-sampled command.

// File: rtl/bl_ecc_pkg.sv
package bl_ecc_pkg;
    localparam int LANE_W  = 8;
    localparam int CHK_W   = 4;
    localparam int CW_W    = LANE_W + CHK_W;
    localparam int N_LANES = 2;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_NOOUT = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } port_state_e;
endpackage

// File: rtl/bl_ecc_enc.sv
module bl_ecc_enc
    import bl_ecc_pkg::*;
(
    input  logic [LANE_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    always_comb begin
        cw_o      = '0;
        // data bits at Hamming positions 3,5,6,7,9,10,11,12
        cw_o[2]   = data_i[0];
        cw_o[4]   = data_i[1];
        cw_o[5]   = data_i[2];
        cw_o[6]   = data_i[3];
        cw_o[8]   = data_i[4];
        cw_o[9]   = data_i[5];
        cw_o[10]  = data_i[6];
        cw_o[11]  = data_i[7];
        // check bits at positions 1,2,4,8
        cw_o[0]   = data_i[0] ^ data_i[1] ^ data_i[3] ^ data_i[4] ^ data_i[6];
        cw_o[1]   = data_i[0] ^ data_i[2] ^ data_i[3] ^ data_i[5] ^ data_i[6];
        cw_o[3]   = data_i[1] ^ data_i[2] ^ data_i[3] ^ data_i[7];
        cw_o[7]   = data_i[4] ^ data_i[5] ^ data_i[6] ^ data_i[7];
    end
endmodule

// File: rtl/bl_ecc_dec.sv
module bl_ecc_dec
    import bl_ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [LANE_W-1:0] data_o,
    output logic              fixed_o
);
    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  cw_fix;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw_i[p-1]) syn = syn ^ CHK_W'(p);
        end
        cw_fix = cw_i;
        for (int p = 1; p <= CW_W; p++) begin
            if (syn == CHK_W'(p)) cw_fix[p-1] = ~cw_i[p-1];
        end
        data_o  = {cw_fix[11], cw_fix[10], cw_fix[9], cw_fix[8],
                   cw_fix[6], cw_fix[5], cw_fix[4], cw_fix[2]};
        fixed_o = (syn != '0);
    end
endmodule

// File: rtl/bl_ecc_lane_store.sv
module bl_ecc_lane_store
    import bl_ecc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW_W-1:0]   wr_cw,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [CW_W-1:0]   flip_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW_W-1:0]   rd_cw
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_cw;
        end
        if (flip_en && !(wr_en && (wr_addr == flip_addr))) begin
            cells[flip_addr] <= cells[flip_addr] ^ flip_mask;
        end
    end

    assign rd_cw = cells[rd_addr];
endmodule

// File: rtl/bl_ecc_sram.sv
module bl_ecc_sram
    import bl_ecc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [N_LANES*LANE_W-1:0]   din,
    input  logic                        ce_n,
    input  logic                        oe_n,
    input  logic                        we_n,
    input  logic                        ub_n,
    input  logic                        lb_n,
    output logic [N_LANES*LANE_W-1:0]   dout,
    output logic [N_LANES-1:0]          dout_oe,
    output logic [N_LANES-1:0]          corr_flag,
    input  logic                        inj_en,
    input  logic [ADDR_W-1:0]           inj_addr,
    input  logic [N_LANES-1:0]          inj_lane,
    input  logic [CW_W-1:0]             inj_mask
);
    port_state_e               state_q, state_d;
    logic [N_LANES-1:0]        lane_on;
    logic [N_LANES-1:0]        lane_q;
    logic [N_LANES*LANE_W-1:0] rdat_q;
    logic [N_LANES-1:0]        fix_q;
    logic [N_LANES*LANE_W-1:0] rdat_d;
    logic [N_LANES-1:0]        fix_d;

    assign lane_on = ~{ub_n, lb_n};

    // command classification (transition selection)
    always_comb begin
        if (ce_n)                state_d = ST_DESEL;
        else if (ub_n && lb_n)   state_d = ST_NOOUT;
        else if (!we_n)          state_d = ST_WRITE;
        else if (oe_n)           state_d = ST_NOOUT;
        else                     state_d = ST_READ;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // per-lane storage and coding
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [CW_W-1:0] enc_cw;
        logic [CW_W-1:0] rd_cw;

        bl_ecc_enc u_enc (
            .data_i (din[g*LANE_W +: LANE_W]),
            .cw_o   (enc_cw)
        );

        bl_ecc_lane_store #(.ADDR_W(ADDR_W)) u_store (
            .clk       (clk),
            .wr_en     ((state_d == ST_WRITE) && lane_on[g]),
            .wr_addr   (addr),
            .wr_cw     (enc_cw),
            .flip_en   (inj_en && inj_lane[g]),
            .flip_addr (inj_addr),
            .flip_mask (inj_mask),
            .rd_addr   (addr),
            .rd_cw     (rd_cw)
        );

        bl_ecc_dec u_dec (
            .cw_i    (rd_cw),
            .data_o  (rdat_d[g*LANE_W +: LANE_W]),
            .fixed_o (fix_d[g])
        );
    end

    // read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            rdat_q <= '0;
            fix_q  <= '0;
        end else if (state_d == ST_READ) begin
            lane_q <= lane_on;
            rdat_q <= rdat_d;
            fix_q  <= fix_d & lane_on;
        end else begin
            lane_q <= '0;
            rdat_q <= '0;
            fix_q  <= '0;
        end
    end

    // output decode
    always_comb begin
        dout      = '0;
        dout_oe   = '0;
        corr_flag = '0;
        unique case (state_q)
            ST_READ: begin
                dout_oe   = lane_q;
                corr_flag = fix_q;
                for (int l = 0; l < N_LANES; l++) begin
                    if (lane_q[l]) dout[l*LANE_W +: LANE_W] = rdat_q[l*LANE_W +: LANE_W];
                end
            end
            ST_DESEL, ST_NOOUT, ST_WRITE: begin
                dout      = '0;
                dout_oe   = '0;
                corr_flag = '0;
            end
            default: begin
                dout      = '0;
                dout_oe   = '0;
                corr_flag = '0;
            end
        endcase
    end
endmodule

// File: rtl/bl_ecc_sram_chk.sv
module bl_ecc_sram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        ub_n,
    input logic        lb_n,
    input logic [15:0] dout,
    input logic [1:0]  dout_oe,
    input logic [1:0]  corr_flag
);
    assert_desel_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dout_oe == 2'b00));

    assert_oe_off_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> (dout_oe == 2'b00));

    assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (dout_oe == 2'b00));

    assert_read_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |=> (dout_oe == {~$past(ub_n), ~$past(lb_n)}));

    assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dout_oe[0] |-> (dout[7:0] == 8'h00)) and (!dout_oe[1] |-> (dout[15:8] == 8'h00)));

    assert_flag_on_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((corr_flag & ~dout_oe) == 2'b00));
endmodule

bind bl_ecc_sram bl_ecc_sram_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ub_n      (ub_n),
    .lb_n      (lb_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .corr_flag (corr_flag)
);

// File: tb/bl_ecc_sram_tb_top.sv
`timescale 1ns/1ps
module bl_ecc_sram_tb_top;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [15:0]   dout;
    logic [1:0]    dout_oe;
    logic [1:0]    corr_flag;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [1:0]    inj_lane = '0;
    logic [11:0]   inj_mask = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bl_ecc_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
        .dout(dout), .dout_oe(dout_oe), .corr_flag(corr_flag),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_lane(inj_lane), .inj_mask(inj_mask)
    );

    // controls {ce_n, oe_n, we_n, ub_n, lb_n}
    localparam logic [4:0] C_WR_BOTH  = 5'b01000;
    localparam logic [4:0] C_WR_LO    = 5'b01010;
    localparam logic [4:0] C_WR_HI_OE = 5'b00001;
    localparam logic [4:0] C_RD_BOTH  = 5'b00100;
    localparam logic [4:0] C_RD_HI    = 5'b00101;
    localparam logic [4:0] C_RD_LO    = 5'b00110;
    localparam logic [4:0] C_IDLE     = 5'b11111;
    localparam logic [4:0] C_RD_OEOFF = 5'b01100;
    localparam logic [4:0] C_RD_NOBYT = 5'b00111;
    localparam logic [4:0] C_WR_DESEL = 5'b10000;
    localparam logic [4:0] C_WR_NOBYT = 5'b01011;

    typedef struct packed {
        logic [4:0]  ctl;
        logic [5:0]  a;
        logic [15:0] d;
        logic [1:0]  lanes;
        logic [11:0] mask;
        logic [1:0]  e_oe;
        logic [15:0] e_d;
        logic [1:0]  e_fl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{C_WR_BOTH,  6'd1,  16'hA55A, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd5},  // R5
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA55A, 2'b00, 4'd4},  // R4
        '{C_WR_LO,    6'd1,  16'h33C3, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd5},  // R5
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA5C3, 2'b00, 4'd5},  // R5 lane kept
        '{C_WR_HI_OE, 6'd2,  16'h7E00, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd5},  // R5 oe ignored
        '{C_RD_HI,    6'd2,  16'h0000, 2'b00, 12'h000, 2'b10, 16'h7E00, 2'b00, 4'd4},  // R4
        '{C_IDLE,     6'd1,  16'h0000, 2'b01, 12'h010, 2'b00, 16'h0000, 2'b00, 4'd9},  // R9
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA5C3, 2'b01, 4'd7},  // R7
        '{C_IDLE,     6'd1,  16'h0000, 2'b10, 12'h001, 2'b00, 16'h0000, 2'b00, 4'd9},  // R9
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA5C3, 2'b11, 4'd8},  // R8
        '{C_RD_LO,    6'd1,  16'h0000, 2'b00, 12'h000, 2'b01, 16'h00C3, 2'b01, 4'd8},  // R8
        '{C_WR_LO,    6'd1,  16'h0011, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd11}, // R11
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA511, 2'b10, 4'd11}, // R11
        '{C_RD_OEOFF, 6'd1,  16'h0000, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd3},  // R3
        '{C_RD_NOBYT, 6'd1,  16'h0000, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd3},  // R3
        '{C_WR_DESEL, 6'd1,  16'hFFFF, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd2},  // R2
        '{C_WR_NOBYT, 6'd1,  16'hFFFF, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd3},  // R3
        '{C_RD_BOTH,  6'd1,  16'h0000, 2'b00, 12'h000, 2'b11, 16'hA511, 2'b10, 4'd2},  // R2 no write
        '{C_WR_BOTH,  6'd63, 16'h8001, 2'b00, 12'h000, 2'b00, 16'h0000, 2'b00, 4'd5},  // R5
        '{C_IDLE,     6'd63, 16'h0000, 2'b11, 12'h800, 2'b00, 16'h0000, 2'b00, 4'd9},  // R9
        '{C_RD_BOTH,  6'd63, 16'h0000, 2'b00, 12'h000, 2'b11, 16'h8001, 2'b11, 4'd7},  // R7
        '{C_WR_BOTH,  6'd63, 16'h1234, 2'b11, 12'h004, 2'b00, 16'h0000, 2'b00, 4'd9},  // R9 write wins
        '{C_RD_BOTH,  6'd63, 16'h0000, 2'b00, 12'h000, 2'b11, 16'h1234, 2'b00, 4'd9}   // R9
    };

    task automatic check(input int req, input logic [1:0] e_oe,
                         input logic [15:0] e_d, input logic [1:0] e_fl);
        n_chk++;
        if (dout_oe !== e_oe || dout !== e_d || corr_flag !== e_fl) begin
            n_fail++;
            $display("FAIL R%0d: got oe=%b d=%h fl=%b, expected oe=%b d=%h fl=%b",
                     req, dout_oe, dout, corr_flag, e_oe, e_d, e_fl);
        end
    endtask

    task automatic apply(input logic [4:0] ctl, input logic [5:0] a, input logic [15:0] d,
                         input logic [1:0] lanes, input logic [11:0] mask);
        {ce_n, oe_n, we_n, ub_n, lb_n} = ctl;
        addr     = a;
        din      = d;
        inj_en   = |lanes;
        inj_addr = a;
        inj_lane = lanes;
        inj_mask = mask;
        @(posedge clk);
        @(negedge clk);
        {ce_n, oe_n, we_n, ub_n, lb_n} = C_IDLE;
        inj_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL R0 watchdog expired: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 2'b00, 16'h0000, 2'b00); // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 2'b00, 16'h0000, 2'b00); // R1 after release

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ctl, VECS[i].a, VECS[i].d, VECS[i].lanes, VECS[i].mask);
            check(int'(VECS[i].req), VECS[i].e_oe, VECS[i].e_d, VECS[i].e_fl);
        end

        // R6/R7 sweep: every codeword position of the lower lane, upper lane untouched
        apply(C_WR_BOTH, 6'd5, 16'h6996, 2'b00, 12'h000);
        for (int p = 0; p < 12; p++) begin
            apply(C_IDLE, 6'd5, 16'h0000, 2'b01, 12'(1) << p);
            apply(C_RD_BOTH, 6'd5, 16'h0000, 2'b00, 12'h000);
            check(7, 2'b11, 16'h6996, 2'b01); // R7 single flip at position p+1
            apply(C_WR_LO, 6'd5, 16'h0096, 2'b00, 12'h000);
        end
        // R6: a data-bit flip paired with its check bits is a valid codeword of another byte
        // data bit 0 (pos 3) affects check positions 1 and 2: mask 0x007 gives byte 0x97
        apply(C_IDLE, 6'd5, 16'h0000, 2'b01, 12'h007);
        apply(C_RD_LO, 6'd5, 16'h0000, 2'b00, 12'h000);
        check(6, 2'b01, 16'h0097, 2'b00); // R6 codeword layout
        apply(C_WR_LO, 6'd5, 16'h0096, 2'b00, 12'h000);

        // R1/R10: reset during operation
        apply(C_RD_BOTH, 6'd5, 16'h0000, 2'b00, 12'h000);
        rst_n = 1'b0;
        #1;
        check(1, 2'b00, 16'h0000, 2'b00); // R1 async clear
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        apply(C_RD_BOTH, 6'd5, 16'h0000, 2'b00, 12'h000);
        check(10, 2'b11, 16'h6996, 2'b00); // R10 contents kept
        apply(C_RD_BOTH, 6'd1, 16'h0000, 2'b00, 12'h000);
        check(10, 2'b11, 16'hA511, 2'b10); // R10 stored error kept too

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule